// File: doc/BRIEF.md
# Sleep and Wake Power-Mode Controller

This block decides whether a motor-driver chip is in its low-power Sleep mode or in Active mode. It runs on the system clock and advances its filters only on a one-cycle strobe that arrives at a 100 kHz rate. Two sources can wake the chip. The first is a high-voltage enable pin held high. The second is a bus receive line held at its dominant (low) level. Each source must stay present for a parameterised number of strobes before it counts.

Once Active, the chip stays awake until the microcontroller's keep-alive line does two things in order. It must first be seen high for a qualifying time, and then it must fall and stay low for a qualifying time. The keep-alive line alone can never wake the chip. The block records which source caused the most recent wake and shows that on two diagnostic outputs. The record is released by the first accepted watchdog trigger. Both the watchdog enable and the battery-sense switch enable follow the mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is Active (`active`=1), and `srcLatched`=0.
- R2: In Sleep, `wakePin` high for `PIN_TICKS` consecutive strobes wakes the block. Fewer strobes do not. Any clock cycle with `wakePin` low restarts the count.
- R3: In Sleep, `busLevel` low (0 = dominant) for `BUS_TICKS` consecutive strobes wakes the block. A single-cycle return to 1 restarts the count.
- R4: In Sleep, `keepAlive` has no effect on the mode.
- R5: Active goes to Sleep only when `keepAlive` has first been high for `SLEEP_TICKS` strobes and then low for `SLEEP_TICKS` strobes. A low `keepAlive` with no prior qualified high keeps the block Active.
- R6: Once `keepAlive` has qualified high, a low phase shorter than `SLEEP_TICKS` strobes does not cause Sleep. The qualification survives a later high phase.
- R7: On every wake `srcLatched` becomes 1 and `srcIsBus` shows the source (1 = bus, 0 = pin). Both hold until `wdSync` is pulsed while Active, which clears them to 0. A `wdSync` pulse in Sleep has no effect.
- R8: `wdEnable` and `battSwEn` are 1 in Active and 0 in Sleep.
- R9: While Active, `wakePin` and `busLevel` have no effect on the mode or on the wake-source record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle 100 kHz filter strobe |
| wakePin | input | 1 | High-voltage wake pin level |
| busLevel | input | 1 | Bus receive level, 0 = dominant |
| keepAlive | input | 1 | Keep-awake level from the microcontroller |
| wdSync | input | 1 | Strobe for the first accepted watchdog trigger |
| active | output | 1 | 1 = Active mode, 0 = Sleep |
| wdEnable | output | 1 | Watchdog enable |
| battSwEn | output | 1 | Battery-sense switch enable |
| srcLatched | output | 1 | A wake source is recorded |
| srcIsBus | output | 1 | Recorded source is the bus (valid with srcLatched) |

## Verification
Wake pulses of random length and random source are applied just below, at and above their thresholds. This shows the strobe-counting filters from both sides and confirms that the recorded source matches the one applied. Directed single-cycle glitches inserted mid-filter show the difference between a filter that restarts and one that merely pauses. Keep-alive sequences are also applied: low with no qualified high, a short low blip after qualification, and a full high-then-low. These show that the go-to-sleep path depends on the order of events and not only on the current level. Keep-alive activity in Sleep, wake activity in Active, and watchdog strobes in each mode confirm that these inputs are ignored.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_SLEEP  = 1'b1
  } pmcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sleepMode;
    logic clrArm;
  } pmcCtrl_t;

  // qualified events from datapath to control
  typedef struct packed {
    logic pinOk;
    logic busOk;
    logic sleepOk;
  } pmcEvt_t;

endpackage

// File: rtl/pmc_level_filter.sv
module pmc_level_filter #(
  parameter int THRESH = 2,
  parameter int CNT_W  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic enable,
  input  logic level,
  output logic ok
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt;

  // any cycle without the level restarts the count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!enable || !level) begin
      cnt <= '0;
    end else if (tick && (cnt < LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ok = enable && level && (cnt == LIMIT);

endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int PIN_TICKS   = 2,
  parameter int BUS_TICKS   = 7,
  parameter int SLEEP_TICKS = 2,
  parameter int CNT_W       = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     wakePin,
  input  logic     busLevel,
  input  logic     keepAlive,
  input  pmcCtrl_t ctrl,
  output pmcEvt_t  evt
);
  logic highOk;
  logic armed;
  logic lowOk;

  pmc_level_filter #(.THRESH(PIN_TICKS), .CNT_W(CNT_W)) u_pinFilt (
    .clk(clk), .rstN(rstN), .tick(tick),
    .enable(ctrl.sleepMode), .level(wakePin), .ok(evt.pinOk)
  );

  pmc_level_filter #(.THRESH(BUS_TICKS), .CNT_W(CNT_W)) u_busFilt (
    .clk(clk), .rstN(rstN), .tick(tick),
    .enable(ctrl.sleepMode), .level(!busLevel), .ok(evt.busOk)
  );

  pmc_level_filter #(.THRESH(SLEEP_TICKS), .CNT_W(CNT_W)) u_highFilt (
    .clk(clk), .rstN(rstN), .tick(tick),
    .enable(!ctrl.sleepMode), .level(keepAlive), .ok(highOk)
  );

  pmc_level_filter #(.THRESH(SLEEP_TICKS), .CNT_W(CNT_W)) u_lowFilt (
    .clk(clk), .rstN(rstN), .tick(tick),
    .enable(!ctrl.sleepMode && armed), .level(!keepAlive), .ok(lowOk)
  );

  // keep-alive qualified high; persists until the next sleep entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (ctrl.clrArm) begin
      armed <= 1'b0;
    end else if (highOk) begin
      armed <= 1'b1;
    end
  end

  assign evt.sleepOk = lowOk;

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wdSync,
  input  pmcEvt_t  evt,
  output pmcCtrl_t ctrl,
  output logic     isActive,
  output logic     srcLatched,
  output logic     srcIsBus
);
  pmcMode_e mode;
  pmcMode_e modeNext;
  logic     wakeNow;

  always_comb begin
    modeNext     = mode;
    ctrl.clrArm  = 1'b0;
    wakeNow      = 1'b0;
    unique case (mode)
      MODE_ACTIVE: begin
        if (evt.sleepOk) begin
          modeNext    = MODE_SLEEP;
          ctrl.clrArm = 1'b1;
        end
      end
      MODE_SLEEP: begin
        if (evt.pinOk || evt.busOk) begin
          modeNext = MODE_ACTIVE;
          wakeNow  = 1'b1;
        end
      end
      default: modeNext = MODE_ACTIVE;
    endcase
  end

  assign ctrl.sleepMode = (mode == MODE_SLEEP);
  assign isActive       = (mode == MODE_ACTIVE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_ACTIVE;
    end else begin
      mode <= modeNext;
    end
  end

  // wake-source record; pin wins if both qualify together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcLatched <= 1'b0;
      srcIsBus   <= 1'b0;
    end else if (wakeNow) begin
      srcLatched <= 1'b1;
      srcIsBus   <= !evt.pinOk;
    end else if (isActive && wdSync) begin
      srcLatched <= 1'b0;
      srcIsBus   <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int PIN_TICKS   = 2,
  parameter int BUS_TICKS   = 7,
  parameter int SLEEP_TICKS = 2,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic wakePin,
  input  logic busLevel,
  input  logic keepAlive,
  input  logic wdSync,
  output logic active,
  output logic wdEnable,
  output logic battSwEn,
  output logic srcLatched,
  output logic srcIsBus
);
  pmcCtrl_t ctrl;
  pmcEvt_t  evt;
  logic     isActive;

  pmc_datapath #(
    .PIN_TICKS(PIN_TICKS), .BUS_TICKS(BUS_TICKS),
    .SLEEP_TICKS(SLEEP_TICKS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wakePin(wakePin),
    .busLevel(busLevel), .keepAlive(keepAlive), .ctrl(ctrl), .evt(evt)
  );

  pmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wdSync(wdSync), .evt(evt), .ctrl(ctrl),
    .isActive(isActive), .srcLatched(srcLatched), .srcIsBus(srcIsBus)
  );

  assign active   = isActive;
  assign wdEnable = isActive;
  assign battSwEn = isActive;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic wakePin,
  input logic busLevel,
  input logic keepAlive,
  input logic wdSync,
  input logic active,
  input logic wdEnable,
  input logic srcLatched
);
  // no wake without a wake source present (R2, R3)
  assert_wake_needs_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !wakePin && busLevel) |=> !active);

  // keep-alive high alone never wakes (R4)
  assert_keepalive_no_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!active && keepAlive && !wakePin && busLevel) |=> !active);

  // sleep only follows a cycle with keep-alive low (R5)
  assert_sleep_needs_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (active && keepAlive) |=> active);

  assert_wake_sets_record_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> srcLatched);

  assert_sync_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && wdSync) |=> !srcLatched);

  assert_record_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (srcLatched && !(active && wdSync)) |=> srcLatched);

  assert_wd_off_in_sleep_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> !wdEnable);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wakePin(wakePin), .busLevel(busLevel),
  .keepAlive(keepAlive), .wdSync(wdSync), .active(active),
  .wdEnable(wdEnable), .srcLatched(srcLatched)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int PIN_T = 2;
  localparam int BUS_T = 7;
  localparam int SLP_T = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic wakePin = 1'b0;
  logic busLevel = 1'b1;
  logic keepAlive = 1'b0;
  logic wdSync = 1'b0;
  logic active, wdEnable, battSwEn, srcLatched, srcIsBus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.PIN_TICKS(PIN_T), .BUS_TICKS(BUS_T), .SLEEP_TICKS(SLP_T)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wakePin(wakePin), .busLevel(busLevel),
    .keepAlive(keepAlive), .wdSync(wdSync), .active(active), .wdEnable(wdEnable),
    .battSwEn(battSwEn), .srcLatched(srcLatched), .srcIsBus(srcIsBus)
  );

  function automatic bit expWake(int len, int thr);
    return len >= thr;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one filter strobe, then nine quiet cycles; returns at a negedge
  task automatic tickCycle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic goSleep();
    keepAlive = 1'b1;
    tickCycle(SLP_T);
    keepAlive = 1'b0;
    tickCycle(SLP_T);
  endtask

  task automatic pulseSync();
    @(negedge clk) wdSync = 1'b1;
    @(negedge clk) wdSync = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R8 reset state
    check(active == 1'b1, "R1 active after reset", active, 1);
    check(srcLatched == 1'b0, "R1 no record after reset", srcLatched, 0);
    check(wdEnable && battSwEn, "R8 enables in Active", {wdEnable, battSwEn}, 3);

    // R5 low keep-alive without prior high keeps Active
    tickCycle(5);
    check(active == 1'b1, "R5 low without qualified high", active, 1);

    goSleep();
    check(active == 1'b0, "R5 sleep after high then low", active, 0);
    check(!wdEnable && !battSwEn, "R8 enables off in Sleep", {wdEnable, battSwEn}, 0);

    // R4 keep-alive cannot wake
    keepAlive = 1'b1;
    tickCycle(10);
    keepAlive = 1'b0;
    tickCycle(1);
    check(active == 1'b0, "R4 keep-alive ignored in Sleep", active, 0);

    // R3 bus filter restarts on a one-cycle glitch
    busLevel = 1'b0;
    tickCycle(BUS_T - 2);
    @(negedge clk) busLevel = 1'b1;
    @(negedge clk) busLevel = 1'b0;
    tickCycle(BUS_T - 1);
    check(active == 1'b0, "R3 glitch restarts bus filter", active, 0);
    tickCycle(1);
    check(active == 1'b1, "R3 bus wake after full filter", active, 1);
    check(srcLatched && srcIsBus, "R7 record shows bus", {srcLatched, srcIsBus}, 3);
    busLevel = 1'b1;

    // R5 both enables low after bus wake stays Active
    tickCycle(10);
    check(active == 1'b1, "R5 stays Active after bus wake", active, 1);
    check(srcLatched == 1'b1, "R7 record held", srcLatched, 1);

    pulseSync();
    check(!srcLatched && !srcIsBus, "R7 sync clears record", {srcLatched, srcIsBus}, 0);

    // R9 wake sources ignored while Active
    wakePin = 1'b1;
    busLevel = 1'b0;
    tickCycle(10);
    wakePin = 1'b0;
    busLevel = 1'b1;
    tickCycle(1);
    check(active && !srcLatched, "R9 wake inputs ignored in Active", {active, srcLatched}, 2);

    // R6 short low blip after qualification
    keepAlive = 1'b1;
    tickCycle(SLP_T + 1);
    keepAlive = 1'b0;
    tickCycle(SLP_T - 1);
    keepAlive = 1'b1;
    tickCycle(1);
    keepAlive = 1'b0;
    tickCycle(SLP_T - 1);
    check(active == 1'b1, "R6 short low does not sleep", active, 1);
    tickCycle(1);
    check(active == 1'b0, "R6 arm survives high phase", active, 0);

    // R2 pin filter restart
    wakePin = 1'b1;
    tickCycle(PIN_T - 1);
    @(negedge clk) wakePin = 1'b0;
    @(negedge clk) wakePin = 1'b1;
    tickCycle(PIN_T - 1);
    check(active == 1'b0, "R2 glitch restarts pin filter", active, 0);
    tickCycle(1);
    check(active == 1'b1, "R2 pin wake", active, 1);
    check(srcLatched && !srcIsBus, "R7 record shows pin", {srcLatched, srcIsBus}, 2);
    wakePin = 1'b0;

    // R7 sync in Sleep has no effect
    goSleep();
    pulseSync();
    check(srcLatched == 1'b1, "R7 sync ignored in Sleep", srcLatched, 1);

    // random wake pulses
    for (int t = 0; t < 16; t++) begin
      bit useBus;
      int thr;
      int len;
      useBus = 1'($urandom % 2);
      thr = useBus ? BUS_T : PIN_T;
      len = 1 + int'($urandom % (thr + 2));
      if (useBus) busLevel = 1'b0; else wakePin = 1'b1;
      tickCycle(len);
      busLevel = 1'b1;
      wakePin = 1'b0;
      tickCycle(1);
      check(active == expWake(len, thr),
            useBus ? "R3 random bus pulse" : "R2 random pin pulse",
            active, expWake(len, thr));
      if (active) begin
        check(srcIsBus == useBus, "R7 random source", srcIsBus, useBus);
        goSleep();
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule